// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit linear address into a physical address. It uses a two-level hierarchy of 4 KB tables held in memory. Each request carries a linear address, a write flag and a user flag. The walker reads the directory entry, then the table entry, over a single read/write memory port. It checks the presence and permission flags at both levels. On a successful walk it sets the accessed and dirty flags by writing the entries back. It then returns either the translated address or a fault description.

The linear address splits into three fields. Bits [31:22] index the directory, bits [21:12] index the table, and bits [11:0] are the byte offset within the page. Each entry is 32 bits. Bits [31:12] hold a 4 KB-aligned frame number and the low bits hold flags:

| Bit | Flag |
|-----|------|
| 0 | present |
| 1 | writable |
| 2 | user-accessible |
| 5 | accessed |
| 6 | dirty (table entries only) |

The walker handles one walk at a time. `req_ready_o` is high only when it is idle.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle. `req_ready_o` is 1, and `mem_req_o` and `rsp_valid_o` are 0.
- R2: The first read of a walk is at `{dir_base_i, va[31:22], 2'b00}`. The second read is at `{directory entry[31:12], va[21:12], 2'b00}`. A memory request holds its address and direction until `mem_ack_i`.
- R3: On success `rsp_valid_o` pulses for one cycle with `rsp_fault_o`=0 and `rsp_paddr_o` = `{table entry[31:12], va[11:0]}`.
- R4: A directory entry with bit 0 clear ends the walk with a fault: level 0 (`rsp_fault_lvl_o`=0), type not-present (`rsp_fault_prot_o`=0). No table entry is read.
- R5: A table entry with bit 0 clear gives a fault with level 1 and type not-present.
- R6: Any write needs bit 1 set in both entries. If the directory entry lacks it, the fault is level 0 with type rights (`rsp_fault_prot_o`=1). If only the table entry lacks it, the fault is level 1 with type rights. Supervisor writes are checked the same way.
- R7: A user access needs bit 2 set in both entries. A missing bit gives a rights fault at the level of the entry that lacks it. Supervisor accesses ignore bit 2.
- R8: On success, each entry whose bit 5 is clear is written back with bit 5 set. An entry whose flags would not change is not written.
- R9: On a successful write, the table entry is written back with bit 6 set. Reads never set bit 6, and bit 6 of the directory entry is never changed.
- R10: A faulting walk writes nothing to memory.
- R11: `rsp_fault_addr_o` returns the linear address of the request that produced the response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | 32 | Linear address |
| req_write_i | input | 1 | Access is a write |
| req_user_i | input | 1 | Access is from user mode |
| dir_base_i | input | 20 | Frame number of the page directory |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address of the entry |
| mem_wdata_o | output | 32 | Entry write data |
| mem_ack_i | input | 1 | Access complete, read data valid |
| mem_rdata_i | input | 32 | Entry read data |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_paddr_o | output | 32 | Physical address, zero on fault |
| rsp_fault_o | output | 1 | Walk faulted |
| rsp_fault_lvl_o | output | 1 | Fault level: 0 directory, 1 table |
| rsp_fault_prot_o | output | 1 | Fault type: 0 not present, 1 rights |
| rsp_fault_addr_o | output | 32 | Linear address of the walk |

## Verification
The properties assume a few things about the memory port:
- `mem_ack_i` comes only while `mem_req_o` is high.
- `mem_ack_i` is a single-cycle pulse.
- Requests are offered only while the walker is idle.

The bench memory model acknowledges each access one cycle after it appears and then drops the acknowledge. The driver raises `req_valid_i` for exactly one cycle while `req_ready_o` is high, and only after the previous response has been consumed. The directory and table entries used by any one walk never share an address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned OFS_W   = 12;
  localparam int unsigned FRAME_W = ADDR_W - OFS_W;
  localparam int unsigned LVLS    = 2;

  localparam int unsigned F_P = 0;
  localparam int unsigned F_W = 1;
  localparam int unsigned F_U = 2;
  localparam int unsigned F_A = 5;
  localparam int unsigned F_D = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_DIR, S_RD_TBL, S_WB_DIR, S_WB_TBL, S_RSP
  } ptw_state_e;
endpackage

// File: rtl/ptw_rights.sv
module ptw_rights (
  input  logic [ptw_pkg::F_U:0] flags_i,
  input  logic                  write_i,
  input  logic                  user_i,
  output logic                  present_o,
  output logic                  allow_o
);
  import ptw_pkg::*;
  assign present_o = flags_i[F_P];
  assign allow_o   = (!write_i || flags_i[F_W]) && (!user_i || flags_i[F_U]);
endmodule

// File: rtl/ptw_flag_upd.sv
module ptw_flag_upd #(
  parameter int unsigned ENT_W     = 32,
  parameter bit          CAN_DIRTY = 1'b0
) (
  input  logic [ENT_W-1:0] entry_i,
  input  logic             write_i,
  output logic [ENT_W-1:0] entry_o,
  output logic             chg_o
);
  import ptw_pkg::*;
  always_comb begin
    entry_o         = entry_i;
    entry_o[F_A]    = 1'b1;
    if (CAN_DIRTY && write_i) entry_o[F_D] = 1'b1;
  end
  assign chg_o = (entry_o != entry_i);
endmodule

// File: rtl/ptw_ent_addr.sv
module ptw_ent_addr #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned FRAME_W = 20,
  parameter int unsigned IDX_W   = 10
) (
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int unsigned ENT_LOG = ADDR_W - FRAME_W - IDX_W;
  assign addr_o = {frame_i, idx_i, {ENT_LOG{1'b0}}};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int unsigned ADDR_W  = ptw_pkg::ADDR_W,
  parameter int unsigned IDX_W   = ptw_pkg::IDX_W,
  parameter int unsigned OFS_W   = ptw_pkg::OFS_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [ADDR_W-1:0]         req_vaddr_i,
  input  logic                      req_write_i,
  input  logic                      req_user_i,
  input  logic [ADDR_W-OFS_W-1:0]   dir_base_i,
  output logic                      mem_req_o,
  output logic                      mem_we_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic [ADDR_W-1:0]         mem_wdata_o,
  input  logic                      mem_ack_i,
  input  logic [ADDR_W-1:0]         mem_rdata_i,
  output logic                      rsp_valid_o,
  output logic [ADDR_W-1:0]         rsp_paddr_o,
  output logic                      rsp_fault_o,
  output logic                      rsp_fault_lvl_o,
  output logic                      rsp_fault_prot_o,
  output logic [ADDR_W-1:0]         rsp_fault_addr_o
);
  import ptw_pkg::*;
  localparam int unsigned FRM_W = ADDR_W - OFS_W;
  localparam int unsigned NLVL  = LVLS;

  ptw_state_e       state_q;
  logic [ADDR_W-1:0] vaddr_q;
  logic              wr_q, usr_q;
  logic [FRM_W-1:0]  base_q;
  logic [ADDR_W-1:0] ent_q [NLVL];
  logic              flt_q, flt_lvl_q, flt_prot_q;

  logic [FRM_W-1:0]  lvl_frame [NLVL];
  logic [IDX_W-1:0]  lvl_idx   [NLVL];
  logic [ADDR_W-1:0] ent_addr  [NLVL];
  logic [ADDR_W-1:0] ent_new   [NLVL];
  logic              ent_chg   [NLVL];
  logic              rd_present, rd_allow;

  assign lvl_frame[0] = base_q;
  assign lvl_idx[0]   = vaddr_q[ADDR_W-1 -: IDX_W];
  assign lvl_frame[1] = ent_q[0][ADDR_W-1 -: FRM_W];
  assign lvl_idx[1]   = vaddr_q[OFS_W +: IDX_W];

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    ptw_ent_addr #(.ADDR_W(ADDR_W), .FRAME_W(FRM_W), .IDX_W(IDX_W)) u_addr (
      .frame_i(lvl_frame[l]), .idx_i(lvl_idx[l]), .addr_o(ent_addr[l]));
    ptw_flag_upd #(.ENT_W(ADDR_W), .CAN_DIRTY(l == NLVL - 1)) u_upd (
      .entry_i(ent_q[l]), .write_i(wr_q), .entry_o(ent_new[l]), .chg_o(ent_chg[l]));
  end

  // one checker serves both levels: only the entry being read is judged
  ptw_rights u_rights (
    .flags_i(mem_rdata_i[F_U:0]), .write_i(wr_q), .user_i(usr_q),
    .present_o(rd_present), .allow_o(rd_allow));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      vaddr_q    <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      base_q     <= '0;
      flt_q      <= 1'b0;
      flt_lvl_q  <= 1'b0;
      flt_prot_q <= 1'b0;
      for (int l = 0; l < NLVL; l++) ent_q[l] <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          vaddr_q    <= req_vaddr_i;
          wr_q       <= req_write_i;
          usr_q      <= req_user_i;
          base_q     <= dir_base_i;
          flt_q      <= 1'b0;
          flt_lvl_q  <= 1'b0;
          flt_prot_q <= 1'b0;
          state_q    <= S_RD_DIR;
        end
        S_RD_DIR: if (mem_ack_i) begin
          ent_q[0] <= mem_rdata_i;
          if (!rd_present || !rd_allow) begin
            flt_q      <= 1'b1;
            flt_lvl_q  <= 1'b0;
            flt_prot_q <= rd_present;
            state_q    <= S_RSP;
          end else begin
            state_q <= S_RD_TBL;
          end
        end
        S_RD_TBL: if (mem_ack_i) begin
          ent_q[1] <= mem_rdata_i;
          if (!rd_present || !rd_allow) begin
            flt_q      <= 1'b1;
            flt_lvl_q  <= 1'b1;
            flt_prot_q <= rd_present;
            state_q    <= S_RSP;
          end else begin
            state_q <= S_WB_DIR;
          end
        end
        S_WB_DIR: if (!ent_chg[0] || mem_ack_i) state_q <= S_WB_TBL;
        S_WB_TBL: if (!ent_chg[1] || mem_ack_i) state_q <= S_RSP;
        S_RSP:    state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ent_addr[0];
    mem_wdata_o = ent_new[0];
    unique case (state_q)
      S_RD_DIR: mem_req_o = 1'b1;
      S_RD_TBL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ent_addr[1];
      end
      S_WB_DIR: begin
        mem_req_o = ent_chg[0];
        mem_we_o  = ent_chg[0];
      end
      S_WB_TBL: begin
        mem_req_o   = ent_chg[1];
        mem_we_o    = ent_chg[1];
        mem_addr_o  = ent_addr[1];
        mem_wdata_o = ent_new[1];
      end
      default: ;
    endcase
  end

  assign req_ready_o      = (state_q == S_IDLE);
  assign rsp_valid_o      = (state_q == S_RSP);
  assign rsp_fault_o      = flt_q;
  assign rsp_fault_lvl_o  = flt_lvl_q;
  assign rsp_fault_prot_o = flt_prot_q;
  assign rsp_fault_addr_o = vaddr_q;
  assign rsp_paddr_o      = flt_q ? '0 : {ent_q[1][ADDR_W-1 -: FRM_W], vaddr_q[OFS_W-1:0]};
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_vaddr_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] mem_wdata_o,
  input logic              mem_ack_i,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] rsp_fault_addr_o
);
  import ptw_pkg::*;
  logic [ADDR_W-1:0] cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= '0;
    else if (req_valid_i && req_ready_o) cap_q <= req_vaddr_i;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !rsp_valid_o); // R1

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R2

  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o); // R3

  AST_WB_ACCESSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o[F_A]); // R8

  AST_FAULT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_fault_addr_o == cap_q); // R11
endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_vaddr_i(req_vaddr_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
  .rsp_valid_o(rsp_valid_o), .rsp_fault_addr_o(rsp_fault_addr_o));

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [19:0] dir_base = 20'h00100;
  logic        req_ready, mem_req, mem_we, rsp_valid, rsp_fault, rsp_lvl, rsp_prot;
  logic [31:0] mem_addr, mem_wdata, rsp_paddr, rsp_faddr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #10 clk = ~clk;

  ptw_walker dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_write_i(req_write), .req_user_i(req_user),
    .dir_base_i(dir_base), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault),
    .rsp_fault_lvl_o(rsp_lvl), .rsp_fault_prot_o(rsp_prot), .rsp_fault_addr_o(rsp_faddr));

  int checks = 0, fails = 0;
  int issued = 0, done_cnt = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] rd_log [256];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic void check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endfunction

  // memory model: acknowledges one cycle after a request, then drops ack
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_cnt++;
      end else begin
        mem_rdata <= rd(mem_addr);
        rd_log[rd_cnt % 256] = mem_addr;
        rd_cnt++;
      end
    end
  end

  typedef struct {
    logic        flt, lvl, prot, pte_rd;
    logic [31:0] vaddr, paddr, pde_a, pte_a, pde_e, pte_e;
    int          wr_exp, wr_base, rd_base;
    string       rq;
  } exp_t;
  exp_t sb_q [$];

  task automatic issue(input logic [31:0] va, input logic wr, input logic usr, input string rq);
    exp_t e;
    logic [31:0] pde, pte;
    e.rq = rq; e.vaddr = va; e.flt = 1'b0; e.lvl = 1'b0; e.prot = 1'b0;
    e.paddr = '0; e.pte_rd = 1'b0; e.wr_exp = 0; e.pte_a = '0; e.pte_e = '0;
    e.pde_a = {dir_base, va[31:22], 2'b00};
    pde = rd(e.pde_a); e.pde_e = pde;
    if (!pde[0]) begin e.flt = 1; e.lvl = 0; e.prot = 0; end
    else if ((wr && !pde[1]) || (usr && !pde[2])) begin e.flt = 1; e.lvl = 0; e.prot = 1; end
    else begin
      e.pte_rd = 1'b1;
      e.pte_a = {pde[31:12], va[21:12], 2'b00};
      pte = rd(e.pte_a); e.pte_e = pte;
      if (!pte[0]) begin e.flt = 1; e.lvl = 1; e.prot = 0; end
      else if ((wr && !pte[1]) || (usr && !pte[2])) begin e.flt = 1; e.lvl = 1; e.prot = 1; end
      else begin
        e.paddr = {pte[31:12], va[11:0]};
        e.pde_e = pde | 32'h20;
        e.pte_e = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
        e.wr_exp = int'(e.pde_e != pde) + int'(e.pte_e != pte);
      end
    end
    @(negedge clk);
    e.wr_base = wr_cnt; e.rd_base = rd_cnt;
    sb_q.push_back(e);
    issued++;
    req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait (done_cnt == issued);
  endtask

  // monitor: pops expected item when a response appears
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) check("R3 unexpected response", 32'h1, 32'h0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.rq, " fault"}, {31'h0, rsp_fault}, {31'h0, e.flt});
        if (e.flt) begin
          check({e.rq, " level"}, {31'h0, rsp_lvl}, {31'h0, e.lvl});
          check({e.rq, " type"}, {31'h0, rsp_prot}, {31'h0, e.prot});
        end else check("R3 paddr", rsp_paddr, e.paddr);
        check("R11 fault addr", rsp_faddr, e.vaddr);
        check(e.flt ? "R10 writes" : "R8 writes", wr_cnt - e.wr_base, e.wr_exp);
        check("R2 dir read addr", rd_log[e.rd_base % 256], e.pde_a);
        check("R4 read count", rd_cnt - e.rd_base, e.pte_rd ? 2 : 1);
        if (e.pte_rd) check("R2 tbl read addr", rd_log[(e.rd_base + 1) % 256], e.pte_a);
        check("R8 dir entry", rd(e.pde_a), e.pde_e);
        if (e.pte_rd) check("R9 tbl entry", rd(e.pte_a), e.pte_e);
      end
      done_cnt++;
    end
  end

  function automatic logic [31:0] va(input int d, input int t, input int o);
    return {d[9:0], t[9:0], o[11:0]};
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, issued);
    finish_run();
  end

  initial begin
    // directory at frame 0x00100; tables at frames 0x00200 and 0x00201
    mem[32'h0010_0000] = 32'h0020_0007;
    mem[32'h0010_0004] = 32'h0020_1005;
    mem[32'h0010_0008] = 32'h0020_0003;
    mem[32'h0010_000C] = 32'h0000_0000;
    mem[32'h0010_0FFC] = 32'h0020_1027;
    mem[32'h0020_0000] = 32'h1234_5007;
    mem[32'h0020_0004] = 32'h2345_6005;
    mem[32'h0020_0008] = 32'h3456_7003;
    mem[32'h0020_000C] = 32'h0000_0000;
    mem[32'h0020_0FFC] = 32'h4567_8027;
    mem[32'h0020_1000] = 32'h5678_9007;
    mem[32'h0020_1014] = 32'h6789_A067;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", {31'h0, req_ready}, 32'h1);
    check("R1 mem_req", {31'h0, mem_req}, 32'h0);
    check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);

    issue(va(0, 0, 12'h123), 1, 1, "R9");     // both A and D set
    issue(va(0, 0, 12'h123), 1, 1, "R8");     // nothing changes, no writes
    issue(va(0, 1023, 12'hFFF), 0, 1, "R3");  // top index, max offset
    issue(va(3, 0, 0), 0, 0, "R4");
    issue(va(0, 3, 4), 0, 0, "R5");
    issue(va(0, 1, 8), 1, 1, "R6");           // table entry read-only
    issue(va(1, 0, 0), 1, 0, "R6");           // directory read-only, supervisor
    issue(va(0, 2, 0), 0, 1, "R7");           // table entry supervisor-only
    issue(va(0, 2, 12'h010), 0, 0, "R7");     // supervisor ignores user bit
    issue(va(2, 0, 0), 0, 1, "R7");           // directory supervisor-only
    issue(va(1, 0, 12'h7FF), 0, 1, "R8");     // both A set on read, no D
    issue(va(1, 0, 12'h800), 1, 1, "R6");
    issue(va(1023, 5, 12'hABC), 1, 1, "R8");  // all flags already set
    issue(va(0, 1, 0), 0, 0, "R9");           // read: A only
    issue(va(0, 1, 0), 1, 0, "R6");           // supervisor write, table read-only
    issue(va(0, 2, 12'h020), 1, 0, "R9");     // write sets D on table entry
    repeat (2) @(negedge clk);
    check("R3 single pulse", {31'h0, rsp_valid}, 32'h0);
    finish_run();
  end
endmodule